// File: doc/BRIEF.md
# Partitioned SECDED Error Classifier

This block checks one protected access word that is built from four separately coded parts: an address field, a MAC field, and a 128-bit data word split into a low half (bits 63..0) and a high half (bits 127..64). Each part has its own single-error-correcting, double-error-detecting check vector. The block computes a syndrome for every part in parallel. It repairs any single flipped data bit and folds the four verdicts into one 6-bit error record for a downstream error stack.

Words enter on a valid/ready stream and leave, corrected, on a second valid/ready stream through one register stage. A word is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so back-pressure on `out_ready` stalls the input after at most one buffered word. A buffered word and its record stay constant until they are taken. In the cycle after each accepted word, `err_push` pulses for one cycle if that word carried any error. This pulse does not depend on `out_ready`.

Check vector of a part with K data bits: R is the least value with 2^R >= K+R+1 (6 for 32 bits, 7 for 64 bits). Data bit j takes the (j+1)-th codeword position, counting from 1 and skipping powers of two. Check bit c (c < R) is the XOR of all data bits whose position has bit c set. Check bit R is the even parity over the data and the first R check bits.

Top module: `ecc_part_classifier`

## Requirements
- R1: A word whose four parts all match their check vectors is passed through unchanged, with record 0 and no `err_push`.
- R2: A single flipped data bit in one part is corrected at the output. The record has bit 0 (single) set and that part's bit set: bit 2 for the low data half, bit 3 for the high half, bit 4 for MAC, bit 5 for address.
- R3: A single flipped check bit, including the overall parity bit, sets record bit 0 only. No part bit is set and the data is unchanged.
- R4: Two flipped bits within one part set record bit 1 (double), leave that part's bit clear, and pass that part's data unmodified.
- R5: Parts are judged independently. Errors in several parts set several part bits together, and bits 0 and 1 can both be set in one record.
- R6: `err_push` is high in exactly the cycle after a word is accepted, only when record bit 0 or bit 1 of that word is set, and for one cycle only.
- R7: While `out_valid` is high and `out_ready` is low, the corrected fields and the record hold still and `in_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R8: After reset, `out_valid` and `err_push` are low, the record is 0 and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word can be taken |
| in_addr | input | ADDR_W | Address field |
| in_addr_chk | input | R(ADDR_W)+1 | Address check vector |
| in_mac | input | MAC_W | MAC field |
| in_mac_chk | input | R(MAC_W)+1 | MAC check vector |
| in_dhi | input | HALF_W | High data half |
| in_dhi_chk | input | R(HALF_W)+1 | High half check vector |
| in_dlo | input | HALF_W | Low data half |
| in_dlo_chk | input | R(HALF_W)+1 | Low half check vector |
| out_valid | output | 1 | Corrected word present |
| out_ready | input | 1 | Downstream takes the word |
| out_addr | output | ADDR_W | Corrected address |
| out_mac | output | MAC_W | Corrected MAC |
| out_dhi | output | HALF_W | Corrected high half |
| out_dlo | output | HALF_W | Corrected low half |
| out_rec | output | 6 | Error record {addr,mac,hi,lo,double,single} |
| err_push | output | 1 | One-cycle push of a nonzero record |

## Verification
There is only one register stage, so a wrong syndrome or a wrong classification appears on the cycle after acceptance. It shows up as a wrong record bit, a data bit that was flipped wrongly or left unrepaired, or a missing or extra `err_push`. The sweep flips every data bit and every check bit of every part one at a time, flips adjacent pairs, and combines parts. A fault in any single position map or range test therefore appears as a mismatch on some word. A broken stall path shows up within one stalled cycle as a payload that changes or an `in_ready` that stays high.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // number of Hamming check bits (overall parity excluded) for dw data bits
  function automatic int chk_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // codeword position (from 1) of data bit j; powers of two are skipped
  function automatic int data_pos(input int j);
    int pos;
    int cnt;
    pos = 0;
    cnt = -1;
    while (cnt < j) begin
      pos++;
      if ((pos & (pos - 1)) != 0) cnt++;
    end
    return pos;
  endfunction

  typedef struct packed {
    logic addr_se;
    logic mac_se;
    logic hi_se;
    logic lo_se;
    logic ded;
    logic sec;
  } ecc_rec_t;

endpackage

// File: rtl/secded_part.sv
module secded_part
  import secded_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]          data_i,
  input  logic [chk_bits(DW):0]  chk_i,
  output logic [DW-1:0]          data_o,
  output logic                   sec_o,
  output logic                   ded_o,
  output logic                   hit_o
);
  localparam int R = chk_bits(DW);
  localparam int N = DW + R;

  logic [R-1:0] contrib [DW];
  logic [R-1:0] syn;
  logic         par_mis;
  logic         in_range;
  logic         syn_nz;
  logic         syn_pow;

  // per-bit syndrome contribution and correction
  for (genvar gj = 0; gj < DW; gj++) begin : g_bit
    localparam int P = data_pos(gj);
    assign contrib[gj] = data_i[gj] ? R'(P) : '0;
    assign data_o[gj]  = data_i[gj] ^ (hit_o && (syn == R'(P)));
  end

  // check bit c sits at position 2^c, so it enters the syndrome as itself
  always_comb begin
    syn = chk_i[R-1:0];
    for (int j = 0; j < DW; j++) syn = syn ^ contrib[j];
  end

  assign par_mis  = ^{data_i, chk_i};
  assign syn_nz   = |syn;
  assign syn_pow  = $onehot(syn);
  assign in_range = (32'(syn) <= 32'(N));

  // odd-weight error: correctable when the syndrome points inside the word
  assign sec_o = par_mis && in_range;
  assign ded_o = (!par_mis && syn_nz) || (par_mis && !in_range);
  // a data bit was hit: syndrome is neither zero nor a check position
  assign hit_o = sec_o && syn_nz && !syn_pow;

endmodule

// File: rtl/ecc_out_stage.sv
module ecc_out_stage
  import secded_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 32,
  parameter int HW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] c_addr,
  input  logic [MW-1:0] c_mac,
  input  logic [HW-1:0] c_dhi,
  input  logic [HW-1:0] c_dlo,
  input  ecc_rec_t      c_rec,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [MW-1:0] out_mac,
  output logic [HW-1:0] out_dhi,
  output logic [HW-1:0] out_dlo,
  output ecc_rec_t      out_rec,
  output logic          err_push
);
  logic accept;
  logic fresh;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fresh     <= 1'b0;
      out_addr  <= '0;
      out_mac   <= '0;
      out_dhi   <= '0;
      out_dlo   <= '0;
      out_rec   <= '0;
    end else begin
      fresh <= accept;
      if (accept) begin
        out_valid <= 1'b1;
        out_addr  <= c_addr;
        out_mac   <= c_mac;
        out_dhi   <= c_dhi;
        out_dlo   <= c_dlo;
        out_rec   <= c_rec;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign err_push = fresh && (out_rec.sec || out_rec.ded);

  AST_PUSH_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    err_push |-> $past(in_valid && in_ready)); // R6
  AST_PUSH_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_push |-> (out_rec.sec || out_rec.ded)); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rec) && $stable(out_dlo)
                                   && $stable(out_dhi) && $stable(out_addr) && $stable(out_mac))); // R7
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7

endmodule

// File: rtl/ecc_part_classifier.sv
module ecc_part_classifier
  import secded_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAC_W  = 32,
  parameter int HALF_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ADDR_W-1:0]           in_addr,
  input  logic [chk_bits(ADDR_W):0]   in_addr_chk,
  input  logic [MAC_W-1:0]            in_mac,
  input  logic [chk_bits(MAC_W):0]    in_mac_chk,
  input  logic [HALF_W-1:0]           in_dhi,
  input  logic [chk_bits(HALF_W):0]   in_dhi_chk,
  input  logic [HALF_W-1:0]           in_dlo,
  input  logic [chk_bits(HALF_W):0]   in_dlo_chk,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [ADDR_W-1:0]           out_addr,
  output logic [MAC_W-1:0]            out_mac,
  output logic [HALF_W-1:0]           out_dhi,
  output logic [HALF_W-1:0]           out_dlo,
  output logic [5:0]                  out_rec,
  output logic                        err_push
);
  logic [ADDR_W-1:0] c_addr;
  logic [MAC_W-1:0]  c_mac;
  logic [HALF_W-1:0] c_dhi;
  logic [HALF_W-1:0] c_dlo;
  logic [3:0]        p_sec;
  logic [3:0]        p_ded;
  logic [3:0]        p_hit;
  ecc_rec_t          rec_c;
  ecc_rec_t          rec_q;

  // partition index: 0 low half, 1 high half, 2 MAC, 3 address
  secded_part #(.DW(HALF_W)) u_lo (
    .data_i(in_dlo), .chk_i(in_dlo_chk), .data_o(c_dlo),
    .sec_o(p_sec[0]), .ded_o(p_ded[0]), .hit_o(p_hit[0]));
  secded_part #(.DW(HALF_W)) u_hi (
    .data_i(in_dhi), .chk_i(in_dhi_chk), .data_o(c_dhi),
    .sec_o(p_sec[1]), .ded_o(p_ded[1]), .hit_o(p_hit[1]));
  secded_part #(.DW(MAC_W)) u_mac (
    .data_i(in_mac), .chk_i(in_mac_chk), .data_o(c_mac),
    .sec_o(p_sec[2]), .ded_o(p_ded[2]), .hit_o(p_hit[2]));
  secded_part #(.DW(ADDR_W)) u_addr (
    .data_i(in_addr), .chk_i(in_addr_chk), .data_o(c_addr),
    .sec_o(p_sec[3]), .ded_o(p_ded[3]), .hit_o(p_hit[3]));

  always_comb begin
    rec_c         = '0;
    rec_c.sec     = |p_sec;
    rec_c.ded     = |p_ded;
    rec_c.lo_se   = p_hit[0];
    rec_c.hi_se   = p_hit[1];
    rec_c.mac_se  = p_hit[2];
    rec_c.addr_se = p_hit[3];
  end

  ecc_out_stage #(.AW(ADDR_W), .MW(MAC_W), .HW(HALF_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .c_addr(c_addr), .c_mac(c_mac), .c_dhi(c_dhi), .c_dlo(c_dlo), .c_rec(rec_c),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_mac(out_mac), .out_dhi(out_dhi), .out_dlo(out_dlo),
    .out_rec(rec_q), .err_push(err_push));

  assign out_rec = rec_q;

  AST_PART_NEEDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rec[0] || out_rec[5:2] == 4'b0)); // R2
  AST_PART_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((p_sec & p_ded) == 4'b0)); // R4
  AST_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !err_push); // R8

endmodule

// File: tb/ecc_part_classifier_bench.sv
`timescale 1ns/1ps
module ecc_part_classifier_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, err_push;
  logic [31:0] in_addr = '0, in_mac = '0, out_addr, out_mac;
  logic [6:0]  in_addr_chk = '0, in_mac_chk = '0;
  logic [63:0] in_dhi = '0, in_dlo = '0, out_dhi, out_dlo;
  logic [7:0]  in_dhi_chk = '0, in_dlo_chk = '0;
  logic [5:0]  out_rec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  ecc_part_classifier u_ecc_part_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_addr_chk(in_addr_chk), .in_mac(in_mac), .in_mac_chk(in_mac_chk),
    .in_dhi(in_dhi), .in_dhi_chk(in_dhi_chk), .in_dlo(in_dlo), .in_dlo_chk(in_dlo_chk),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_mac(out_mac),
    .out_dhi(out_dhi), .out_dlo(out_dlo), .out_rec(out_rec), .err_push(err_push));

  // partition p: 0 low half, 1 high half, 2 MAC, 3 address; record bit p+2
  int          pw [4] = '{64, 64, 32, 32};
  logic [63:0] tx_d [4];
  logic [8:0]  tx_c [4];
  logic [63:0] ex_d [4];
  logic [5:0]  ex_rec;

  function automatic int nchk(input int k);
    int r = 1;
    while ((1 << r) < k + r + 1) r++;
    return r;
  endfunction

  function automatic logic [8:0] encode(input logic [63:0] d, input int k);
    logic [8:0] c = '0;
    int r = nchk(k);
    int pos = 0;
    logic par = 1'b0;
    for (int j = 0; j < k; j++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      for (int b = 0; b < r; b++) if (pos[b]) c[b] ^= d[j];
      par ^= d[j];
    end
    for (int b = 0; b < r; b++) par ^= c[b];
    c[r] = par;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fresh_word();
    for (int p = 0; p < 4; p++) begin
      tx_d[p] = {$urandom, $urandom};
      if (pw[p] == 32) tx_d[p][63:32] = '0;
      tx_c[p] = encode(tx_d[p], pw[p]);
      ex_d[p] = tx_d[p];
    end
    ex_rec = '0;
  endtask

  task automatic drive_word();
    in_dlo = tx_d[0]; in_dlo_chk = tx_c[0][7:0];
    in_dhi = tx_d[1]; in_dhi_chk = tx_c[1][7:0];
    in_mac = tx_d[2][31:0]; in_mac_chk = tx_c[2][6:0];
    in_addr = tx_d[3][31:0]; in_addr_chk = tx_c[3][6:0];
  endtask

  task automatic check_out(input string req);
    check(out_valid == 1'b1, req, 64'(out_valid), 64'd1);
    check(out_dlo == ex_d[0], req, out_dlo, ex_d[0]);
    check(out_dhi == ex_d[1], req, out_dhi, ex_d[1]);
    check(out_mac == ex_d[2][31:0], req, 64'(out_mac), ex_d[2]);
    check(out_addr == ex_d[3][31:0], req, 64'(out_addr), ex_d[3]);
    check(out_rec == ex_rec, req, 64'(out_rec), 64'(ex_rec));
  endtask

  // send one word with out_ready high; check result, push and push drop
  task automatic send(input string req);
    @(negedge clk);
    drive_word();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(req);
    check(err_push == (ex_rec[1:0] != 2'b0), {req, " R6 push"}, 64'(err_push), 64'(ex_rec[1:0] != 2'b0));
    @(negedge clk);
    check(err_push == 1'b0, {req, " R6 single pulse"}, 64'(err_push), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] keep_lo;
    logic [5:0]  keep_rec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(out_valid == 1'b0, "R8 out_valid", 64'(out_valid), 64'd0);
    check(err_push == 1'b0, "R8 push", 64'(err_push), 64'd0);
    check(out_rec == 6'd0, "R8 record", 64'(out_rec), 64'd0);
    check(in_ready == 1'b1, "R8 in_ready", 64'(in_ready), 64'd1);

    // R1 clean words
    for (int n = 0; n < 16; n++) begin
      fresh_word();
      send("R1 clean");
    end

    // R2 every single data bit of every part
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < pw[p]; i++) begin
        fresh_word();
        tx_d[p][i] ^= 1'b1;
        ex_rec = 6'b000001 | (6'b000100 << p);
        send("R2 single data");
      end

    // R3 every check bit, overall parity included
    for (int p = 0; p < 4; p++)
      for (int i = 0; i <= nchk(pw[p]); i++) begin
        fresh_word();
        tx_c[p][i] ^= 1'b1;
        ex_rec = 6'b000001;
        send("R3 check bit");
      end

    // R4 adjacent data pairs, and data plus check bit
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < pw[p]; i++) begin
        fresh_word();
        tx_d[p][i] ^= 1'b1;
        tx_d[p][(i + 1) % pw[p]] ^= 1'b1;
        ex_d[p] = tx_d[p];
        ex_rec = 6'b000010;
        send("R4 double data");
      end
      fresh_word();
      tx_d[p][3] ^= 1'b1;
      tx_c[p][0] ^= 1'b1;
      ex_d[p] = tx_d[p];
      ex_rec = 6'b000010;
      send("R4 data+check");
    end

    // R5 several parts at once
    fresh_word();
    for (int p = 0; p < 4; p++) tx_d[p][p + 5] ^= 1'b1;
    ex_rec = 6'b111101;
    send("R5 all single");

    fresh_word();
    tx_d[0][10] ^= 1'b1;
    tx_d[1][60] ^= 1'b1;
    tx_d[2][1] ^= 1'b1; tx_d[2][2] ^= 1'b1;
    ex_d[2] = tx_d[2];
    ex_rec = 6'b001111;
    send("R5 mixed sec ded");

    fresh_word();
    tx_d[3][31] ^= 1'b1;
    tx_c[2][6] ^= 1'b1;
    ex_rec = 6'b100001;
    send("R5 addr data + mac parity");

    // R7 back-pressure
    fresh_word();
    tx_d[1][7] ^= 1'b1;
    ex_rec = 6'b001001;
    keep_lo = ex_d[0];
    keep_rec = ex_rec;
    @(negedge clk);
    out_ready = 1'b0;
    drive_word();
    in_valid = 1'b1;
    @(negedge clk);
    check_out("R7 first word");
    check(err_push == 1'b1, "R6 push under stall", 64'(err_push), 64'd1);
    check(in_ready == 1'b0, "R7 in_ready low", 64'(in_ready), 64'd0);
    fresh_word();
    drive_word();
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check(out_dlo == keep_lo, "R7 hold data", out_dlo, keep_lo);
      check(out_rec == keep_rec, "R7 hold record", 64'(out_rec), 64'(keep_rec));
      check(in_ready == 1'b0, "R7 stall ready", 64'(in_ready), 64'd0);
      check(err_push == 1'b0, "R6 no repeat push", 64'(err_push), 64'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R7 ready when draining", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R7 second word");
    check(err_push == 1'b0, "R6 clean no push", 64'(err_push), 64'd0);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 drained", 64'(out_valid), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule